// File: doc/BRIEF.md
# Multiphase Clock Divider with Phase Select

This block takes one fast clock and produces four main clocks, one half-rate companion, one double-rate companion and a complementary pair that toggles on every divider step. All of it runs synchronously in the fast clock domain. Every output is a registered logic level. A single phase counter of period N fast ticks is the time base. N is 4 or 8, set by a divide-select input. Each main output is high for the first half of its own shifted copy of that period. The shift of each output is set by a 2-bit pattern code, and two units are available: a quarter of the period (Q = N/4 ticks) or one fast tick (t).

Two enables switch their banks of outputs to a static low level. A synchronous active-low reset sets every output to a known state. A change to the pattern code or the divide select is held off until the counter wraps, so no output can produce a runt pulse. In test mode the counter stops advancing on every fast tick. Instead it takes one step for each rising edge of a slow reference input, which drives the dividers open loop.

Top module: `mcd_multiphase_div`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter clears to phase index 0, `fout`, `hfout` and `x2fout` go low, `fast_p` goes low and `fast_n` goes high. The first step after release moves to phase index 1.
- R2: `div_sel` = 0 gives a period of N = 4 steps and `div_sel` = 1 gives N = 8. After each step the phase index p becomes (p+1) mod N. Output i is high when ((p − lag_i) mod N) < N/2.
- R3: Pattern code 00 gives all four lags as 0, so the four main outputs are identical.
- R4: Pattern code 01 gives lags 0, Q, 2Q, 3Q for outputs 0..3, with Q = N/4.
- R5: Pattern code 10 gives lags 0, +1, −1, −Q for outputs 0..3. A negative lag is a lead.
- R6: Pattern code 11 gives lags 0, 1, 2, 3 fast ticks for outputs 0..3.
- R7: `hfout` starts low and inverts each time the phase index wraps to 0, so its period is 2N steps.
- R8: `x2fout` is high when (p mod N/2) < N/4, so its period is N/2 steps.
- R9: From the cycle after `en_a` is low, `fout[1:0]` is low. From the cycle after `en_b` is low, `fout[3:2]`, `hfout` and `x2fout` are low. The enables have no effect on `fast_p` or `fast_n`.
- R10: `phsel` and `div_sel` are loaded only during reset, or on the step where the phase index wraps to 0. At any other time a change has no effect.
- R11: With `test_en` high, the counter takes one step for each rising edge of `ref_in`. A level that is high first at edge e produces the step at edge e+1. Without such a rising edge the counter holds.
- R12: `fast_p` inverts on every step and `fast_n` is always its complement. Neither depends on `phsel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous reset, active low |
| test_en | input | 1 | Open-loop mode: step on ref_in rising edges |
| ref_in | input | 1 | Reference level used for stepping in test mode |
| div_sel | input | 1 | 0: period 4 steps, 1: period 8 steps |
| phsel | input | 2 | Phase pattern code |
| en_a | input | 1 | Enable for fout[1:0] |
| en_b | input | 1 | Enable for fout[3:2], hfout, x2fout |
| fout | output | 4 | Main phased outputs |
| hfout | output | 1 | Half-rate output |
| x2fout | output | 1 | Double-rate output |
| fast_p | output | 1 | Step toggle, true side |
| fast_n | output | 1 | Step toggle, complement side |

## Verification
The bench runs all four pattern codes under both divide settings. Because each pattern gives a different lag vector, an error in a single lag entry or in the sign of a lead shows up in one specific output bit. The pattern code and the divide select are changed in the middle of a period, which separates loading at the wrap from loading at once. All four enable combinations are exercised, which shows which outputs belong to each bank and that the step pair is not gated. In test mode the reference pulses with gaps of different lengths and is also held high for a long time, which tells edge stepping apart from level stepping.

// File: rtl/mcd_pkg.sv
// Shared types and the lag table for the multiphase divider.
// Assumes the counter is at most 8 bits wide and there are four main outputs.
package mcd_pkg;

    localparam int NUM_FOUT = 4;

    typedef enum logic [1:0] {
        PH_ALIGN = 2'b00,
        PH_QUAD  = 2'b01,
        PH_MIXED = 2'b10,
        PH_STEP  = 2'b11
    } ph_mode_e;

    // Lag of output idx in fast ticks, two's complement (a negative value is a lead).
    function automatic logic [7:0] lag_ticks(ph_mode_e mode, int idx, logic [7:0] quarter);
        logic [7:0] k;
        k = 8'(idx);
        case (mode)
            PH_QUAD:  lag_ticks = 8'(k * quarter);
            PH_STEP:  lag_ticks = k;
            PH_MIXED: begin
                case (idx)
                    1:       lag_ticks = 8'd1;
                    2:       lag_ticks = 8'hFF;
                    3:       lag_ticks = 8'(8'd0 - quarter);
                    default: lag_ticks = 8'd0;
                endcase
            end
            default:  lag_ticks = 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/mcd_ref_step.sv
// Builds the step enable. In normal mode it steps on every fast tick. In test
// mode it steps once per rising edge of ref_in, seen through two registers.
// Assumes ref_in changes no faster than once every two fast ticks.
module mcd_ref_step (
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic ref_in,
    output logic adv
);
    logic ref_s1_q;
    logic ref_s2_q;

    // Sample the reference and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_s1_q <= 1'b0;
            ref_s2_q <= 1'b0;
        end else begin
            ref_s1_q <= ref_in;
            ref_s2_q <= ref_s1_q;
        end
    end

    // Select the stepping source.
    always_comb begin
        adv = test_en ? (ref_s1_q & ~ref_s2_q) : 1'b1;
    end
endmodule

// File: rtl/mcd_tick_counter.sv
// Phase counter with period 4 or 8 and the active configuration registers.
// The configuration is loaded in reset and only at the wrap to zero after that.
// Assumes CNT_W >= 3 so that a quarter period is at least one tick.
module mcd_tick_counter
    import mcd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             div_sel,
    input  logic [1:0]       phsel,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             div_q,
    output logic             div_d,
    output ph_mode_e         ph_q,
    output ph_mode_e         ph_d,
    output logic             wrap
);
    localparam int DIV_LO = 2 ** (CNT_W - 1);
    localparam int DIV_HI = 2 ** CNT_W;
    localparam logic [CNT_W-1:0] MASK_LO = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] MASK_HI = CNT_W'(DIV_HI - 1);

    logic [CNT_W-1:0] mask;

    // Next counter value and wrap detection under the active divide.
    always_comb begin
        mask  = div_q ? MASK_HI : MASK_LO;
        cnt_d = adv ? ((cnt_q + CNT_W'(1)) & mask) : cnt_q;
        wrap  = adv && (cnt_d == '0);
        div_d = wrap ? div_sel : div_q;
        ph_d  = wrap ? ph_mode_e'(phsel) : ph_q;
    end

    // State update, with the configuration taken from the inputs during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= div_sel;
            ph_q  <= ph_mode_e'(phsel);
        end else begin
            cnt_q <= cnt_d;
            div_q <= div_d;
            ph_q  <= ph_d;
        end
    end
endmodule

// File: rtl/mcd_phase_gen.sv
// Combinational level of each main output for a given counter value and pattern.
// Assumes the counter wraps at a power of two no larger than 2**CNT_W.
module mcd_phase_gen
    import mcd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0]    cnt,
    input  logic                div,
    input  ph_mode_e            ph,
    output logic [NUM_FOUT-1:0] lvl
);
    localparam int DIV_LO = 2 ** (CNT_W - 1);
    localparam int DIV_HI = 2 ** CNT_W;

    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] half;
    logic [7:0]       quarter;

    // Period-dependent constants.
    always_comb begin
        mask    = div ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
        half    = div ? CNT_W'(DIV_HI / 2) : CNT_W'(DIV_LO / 2);
        quarter = div ? 8'(DIV_HI / 4) : 8'(DIV_LO / 4);
    end

    for (genvar i = 0; i < NUM_FOUT; i++) begin : g_out
        logic [7:0]       lag;
        logic [CNT_W-1:0] shifted;
        // Shift the counter back by this output's lag and compare with half a period.
        always_comb begin
            lag     = lag_ticks(ph, i, quarter);
            shifted = (cnt - lag[CNT_W-1:0]) & mask;
            lvl[i]  = (shifted < half);
        end
    end
endmodule

// File: rtl/mcd_out_stage.sv
// Output registers: bank gating, half-rate and double-rate outputs, step toggle pair.
// Assumes the inputs are the next-state values from the counter.
module mcd_out_stage
    import mcd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                wrap,
    input  logic [CNT_W-1:0]    cnt_d,
    input  logic                div_d,
    input  logic [NUM_FOUT-1:0] lvl,
    input  logic                en_a,
    input  logic                en_b,
    output logic [NUM_FOUT-1:0] fout,
    output logic                hfout,
    output logic                x2fout,
    output logic                fast_p,
    output logic                fast_n,
    output logic                hf_q
);
    localparam int DIV_LO = 2 ** (CNT_W - 1);
    localparam int DIV_HI = 2 ** CNT_W;
    localparam int HALF_N = NUM_FOUT / 2;

    logic [CNT_W-1:0]    sub_mask;
    logic [CNT_W-1:0]    sub_half;
    logic                x2_lvl;
    logic                hf_d;
    logic [NUM_FOUT-1:0] bank_en;

    // Double-rate level, next half-rate state and per-output enables.
    always_comb begin
        sub_mask = div_d ? CNT_W'(DIV_HI / 2 - 1) : CNT_W'(DIV_LO / 2 - 1);
        sub_half = div_d ? CNT_W'(DIV_HI / 4) : CNT_W'(DIV_LO / 4);
        x2_lvl   = ((cnt_d & sub_mask) < sub_half);
        hf_d     = wrap ? ~hf_q : hf_q;
        bank_en  = {{(NUM_FOUT - HALF_N){en_b}}, {HALF_N{en_a}}};
    end

    // Register all outputs, gated by their bank enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fout   <= '0;
            hfout  <= 1'b0;
            x2fout <= 1'b0;
            hf_q   <= 1'b0;
            fast_p <= 1'b0;
            fast_n <= 1'b1;
        end else begin
            fout   <= lvl & bank_en;
            hfout  <= hf_d & en_b;
            x2fout <= x2_lvl & en_b;
            hf_q   <= hf_d;
            if (adv) begin
                fast_p <= ~fast_p;
                fast_n <= fast_p;
            end
        end
    end
endmodule

// File: rtl/mcd_multiphase_div.sv
// Top of the multiphase divider: step source, phase counter, phase decode, output stage.
// Assumes a single fast clock and a synchronous active-low reset.
module mcd_multiphase_div
    import mcd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        test_en,
    input  logic        ref_in,
    input  logic        div_sel,
    input  logic [1:0]  phsel,
    input  logic        en_a,
    input  logic        en_b,
    output logic [3:0]  fout,
    output logic        hfout,
    output logic        x2fout,
    output logic        fast_p,
    output logic        fast_n
);
    logic                adv;
    logic                wrap;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_d;
    logic                div_q;
    logic                div_d;
    ph_mode_e            ph_q;
    ph_mode_e            ph_d;
    logic [NUM_FOUT-1:0] lvl;
    logic                hf_q;

    mcd_ref_step u_step (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .ref_in(ref_in), .adv(adv)
    );

    mcd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv), .div_sel(div_sel), .phsel(phsel),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .div_q(div_q), .div_d(div_d),
        .ph_q(ph_q), .ph_d(ph_d), .wrap(wrap)
    );

    mcd_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .cnt(cnt_d), .div(div_d), .ph(ph_d), .lvl(lvl)
    );

    mcd_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .adv(adv), .wrap(wrap), .cnt_d(cnt_d),
        .div_d(div_d), .lvl(lvl), .en_a(en_a), .en_b(en_b), .fout(fout),
        .hfout(hfout), .x2fout(x2fout), .fast_p(fast_p), .fast_n(fast_n),
        .hf_q(hf_q)
    );
endmodule

// File: rtl/mcd_multiphase_div_chk.sv
// Assertion checker for the multiphase divider, attached through bind.
module mcd_multiphase_div_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic [CNT_W-1:0] cnt_q,
    input logic             div_q,
    input logic [1:0]       ph_q,
    input logic             hf_q,
    input logic             en_a,
    input logic             en_b,
    input logic [3:0]       fout,
    input logic             hfout,
    input logic             x2fout,
    input logic             fast_p,
    input logic             fast_n
);
    logic was_reset_q = 1'b0;

    // Remember that the previous edge saw reset asserted.
    always_ff @(posedge clk) begin
        was_reset_q <= !rst_n;
    end

    // Outputs after a reset edge are in their reset state.
    always_ff @(posedge clk) begin
        if (was_reset_q) begin
            AST_RESET_QUIET: assert (fout == 4'b0 && !hfout && !x2fout && !fast_p && fast_n); // R1
        end
    end

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == 2'b00 && $past(en_a) && $past(en_b)) |-> (fout == 4'h0 || fout == 4'hF)); // R3
    AST_HF_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hf_q) |-> (cnt_q == '0)); // R7
    AST_BANK_A_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_a |=> (fout[1:0] == 2'b00)); // R9
    AST_BANK_B_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_b |=> (fout[3:2] == 2'b00 && !hfout && !x2fout)); // R9
    AST_CFG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ph_q) || !$stable(div_q)) |-> (cnt_q == '0)); // R10
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_q)); // R11
    AST_PAIR_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        fast_p != fast_n); // R12
endmodule

bind mcd_multiphase_div mcd_multiphase_div_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cnt_q(cnt_q), .div_q(div_q),
    .ph_q(ph_q), .hf_q(hf_q), .en_a(en_a), .en_b(en_b), .fout(fout),
    .hfout(hfout), .x2fout(x2fout), .fast_p(fast_p), .fast_n(fast_n)
);

// File: tb/mcd_multiphase_div_bench.sv
module mcd_multiphase_div_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en = 1'b0;
    logic       ref_in = 1'b0;
    logic       div_sel = 1'b0;
    logic [1:0] phsel = 2'b00;
    logic       en_a = 1'b1;
    logic       en_b = 1'b1;
    logic [3:0] fout;
    logic       hfout, x2fout, fast_p, fast_n;

    int total = 0;
    int fails = 0;
    bit done = 0;

    // model state
    int p = 0;
    bit hf = 0, fp = 0, s1 = 0, s2 = 0, act_div = 0, in_reset = 1;
    int act_ph = 0;
    bit [3:0] e_f = 0;
    bit e_h = 0, e_x = 0, e_fp = 0, e_fn = 1;

    always #10 clk = ~clk;

    mcd_multiphase_div u_mcd_multiphase_div (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .ref_in(ref_in),
        .div_sel(div_sel), .phsel(phsel), .en_a(en_a), .en_b(en_b),
        .fout(fout), .hfout(hfout), .x2fout(x2fout), .fast_p(fast_p), .fast_n(fast_n)
    );

    function automatic bit lvl_of(int pi, int n, int ph, int i);
        int q = n / 4;
        int lag = 0;
        case (ph)
            1: lag = i * q;
            2: lag = (i == 1) ? 1 : (i == 2) ? -1 : (i == 3) ? -q : 0;
            3: lag = i;
            default: lag = 0;
        endcase
        return (((pi - lag) % n + n) % n) < n / 2;
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (p=%0d ph=%0d div=%0d)", tag, got, exp, p, act_ph, act_div);
        end
    endtask

    function automatic string ftag(bit en);
        if (in_reset) return "R1";
        if (test_en) return "R11";
        if (!en) return "R9";
        if (phsel != 2'(act_ph) || div_sel != act_div) return "R10";
        case (act_ph)
            0: return "R2 R3";
            1: return "R2 R4";
            2: return "R2 R5";
            default: return "R2 R6";
        endcase
    endfunction

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic cyc();
        int n;
        bit step;
        @(posedge clk);
        if (!rst_n) begin
            in_reset = 1; p = 0; hf = 0; fp = 0; s1 = 0; s2 = 0;
            act_div = div_sel; act_ph = int'(phsel);
            e_f = 0; e_h = 0; e_x = 0; e_fp = 0; e_fn = 1;
        end else begin
            in_reset = 0;
            step = test_en ? (s1 && !s2) : 1'b1;
            s2 = s1; s1 = ref_in;
            n = act_div ? 8 : 4;
            if (step) begin
                p = (p + 1) % n;
                fp = !fp;
                if (p == 0) begin
                    hf = !hf; act_div = div_sel; act_ph = int'(phsel);
                end
            end
            n = act_div ? 8 : 4;
            for (int i = 0; i < 4; i++)
                e_f[i] = lvl_of(p, n, act_ph, i) & ((i < 2) ? en_a : en_b);
            e_h = hf & en_b;
            e_x = ((p % (n / 2)) < n / 4) & en_b;
            e_fp = fp; e_fn = !fp;
        end
        @(negedge clk);
        check(ftag(en_a), {2'b0, fout[1:0]}, {2'b0, e_f[1:0]});
        check(ftag(en_b), {2'b0, fout[3:2]}, {2'b0, e_f[3:2]});
        check(in_reset ? "R1" : (!en_b ? "R9" : "R7"), {3'b0, hfout}, {3'b0, e_h});
        check(in_reset ? "R1" : (!en_b ? "R9" : "R8"), {3'b0, x2fout}, {3'b0, e_x});
        check(in_reset ? "R1" : (test_en ? "R11" : "R12"), {2'b0, fast_p, fast_n}, {2'b0, e_fp, e_fn});
    endtask

    task automatic run(int cycles);
        for (int k = 0; k < cycles; k++) cyc();
    endtask

    initial begin
        run(3);                                  // R1 reset state
        rst_n = 1'b1;
        run(20);
        // R2..R6 and R10: every divide and pattern, changed off the wrap point
        for (int d = 0; d < 2; d++) begin
            for (int ph = 0; ph < 4; ph++) begin
                run(1 + ph);
                div_sel = d[0];
                phsel = 2'(ph);
                run(30);
            end
        end
        // R9: every enable combination under the quadrature pattern
        phsel = 2'b01;
        for (int e = 0; e < 4; e++) begin
            en_a = e[0]; en_b = e[1];
            run(13);
        end
        en_a = 1'b1; en_b = 1'b1;
        div_sel = 1'b0; run(3); phsel = 2'b10; run(20);
        // R11: open-loop stepping with uneven pulses, and a long high level
        test_en = 1'b1;
        run(4);
        for (int g = 0; g < 12; g++) begin
            ref_in = 1'b1; run(2 + g % 3);
            ref_in = 1'b0; run(2 + (g * 5) % 4);
        end
        ref_in = 1'b1; run(10);
        ref_in = 1'b0; run(3);
        test_en = 1'b0;
        run(10);
        // R1: reset in mid-run, then restart
        rst_n = 1'b0; phsel = 2'b11; div_sel = 1'b1;
        run(2);
        rst_n = 1'b1;
        run(20);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule